// File: doc/BRIEF.md
# Capture Sample Queue with Event Registers

This block sits behind the decimation filters of a multi-channel microphone capture path. Each filter delivers finished 24-bit samples together with the number of the channel they belong to. The block stores them in one shared first-in first-out queue of 16 words. Software or a DMA engine drains the queue through a single holding address. Every word read back carries the sample in its low three bytes and the channel number in its top byte, so samples from different channels can be told apart after they have been merged into one stream.

Alongside the queue sits a small event register set. It holds four level flags that describe the queue and two sticky error flags: a dropped sample (overrun) and a read of an empty queue (underrun). Reading the status address clears the error flags. A write-one-to-set enable address and a write-one-to-clear disable address build an interrupt mask, and the interrupt line is raised while any flagged event is also enabled. A burst size of 1, 2, 4 or 8 words is programmed in the mode word. The DMA request stays high while at least that many words wait in the queue. A control write performs a software reset that empties the queue and clears the error flags.

Top module: `capture_queue_top`

## Requirements
- R1: Samples leave in arrival order. Each word read at holding address 0x0C has the channel number in bits [31:24] and the sample in bits [23:0]. The queue holds 16 words.
- R2: A read of address 0x0C pops one word. A read of 0x0C while the queue is empty returns 0 and sets the underrun flag, status bit 4.
- R3: A push while the queue holds 16 words and no pop occurs in that cycle is dropped and sets the overrun flag, status bit 5. A push and a pop in the same cycle on a full queue both take effect and raise no overrun.
- R4: Status address 0x20 reports level flags: bit 0 set when the queue is not empty, bit 1 set when it is empty, bit 2 set when it is full, and bit 3 set when the word count is at least the burst size. Bits above 5 read 0.
- R5: A read of 0x20 clears status bits 4 and 5 after returning them. An error event in the same cycle as that read is kept.
- R6: Writing 1s to 0x14 sets the matching bits of the 6-bit interrupt mask, and writing 1s to 0x18 clears them. Address 0x1C reads the mask. A write to 0x1C changes nothing.
- R7: The interrupt output is high exactly while some status bit and its mask bit are both set.
- R8: The burst size lives in mode bits [31:28] at address 0x04 and reads back there. A write of any value other than 1, 2, 4 or 8 stores 1. The DMA request is high while the word count is at least the burst size.
- R9: A write with bit 0 set to control address 0x00 empties the queue and clears bits 4 and 5. It keeps the mask and the burst size. A push in the same cycle is discarded.
- R10: Address 0x50 returns the version constant in bits [11:0] with the upper bits 0. Unmapped addresses read 0.
- R11: After reset the queue is empty, the mask is 0, the burst size is 1, and the interrupt and DMA request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Filter offers a sample this cycle |
| pushChan | input | 2 | Channel number of the offered sample |
| pushSample | input | 24 | Offered sample |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects at the clock edge) |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |
| dmaReq | output | 1 | A burst of data is available |

## Verification
Two pairs of functions can fall in the same cycle here. The first is a sample push and a holding read on a full queue. The second is an overrun event and the status read that clears the error flags. The bench drives both strobes on the same clock edge. For the first pair, it drains the whole queue and compares every word: it expects the simultaneous sample at the tail, the word offered during the earlier overrun missing, and a status read showing no overrun. For the second pair, it checks that the clearing read returns the old value and that the next status read still shows the overrun.

// File: rtl/capture_queue_pkg.sv
package capture_queue_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h00;
  localparam logic [7:0] ADDR_MODE   = 8'h04;
  localparam logic [7:0] ADDR_HOLD   = 8'h0C;
  localparam logic [7:0] ADDR_ENSET  = 8'h14;
  localparam logic [7:0] ADDR_ENCLR  = 8'h18;
  localparam logic [7:0] ADDR_MASK   = 8'h1C;
  localparam logic [7:0] ADDR_STATUS = 8'h20;
  localparam logic [7:0] ADDR_VER    = 8'h50;

  localparam int EVT_W = 6;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } queueStrobe_t;
endpackage

// File: rtl/capture_queue_store.sv
module capture_queue_store
  import capture_queue_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  queueStrobe_t      strobe,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] headWord,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) mem[wrPtr] <= inWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  assign headWord = mem[rdPtr];
endmodule

// File: rtl/capture_queue_ctrl.sv
module capture_queue_ctrl
  import capture_queue_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int VERSION = 12'h2B1,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic [CNT_W-1:0] count,
  input  logic [31:0]      headWord,
  output queueStrobe_t     strobe,
  output logic [31:0]      regRdData,
  output logic [EVT_W-1:0] maskReg,
  output logic             ovrFlag,
  output logic             udrFlag,
  output logic             irq,
  output logic             dmaReq
);
  logic [3:0]       burstSize;
  logic             isEmpty, isFull, burstHit;
  logic             holdRead, statRead, ovrEvent, udrEvent;
  logic [EVT_W-1:0] statusWord;

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_W'(DEPTH));
  assign burstHit = 32'(count) >= 32'(burstSize);
  assign holdRead = regRdEn && (regAddr == ADDR_HOLD);
  assign statRead = regRdEn && (regAddr == ADDR_STATUS);

  always_comb begin
    strobe.flush = regWrEn && (regAddr == ADDR_CTRL) && regWrData[0];
    strobe.pop   = holdRead && !isEmpty;
    strobe.push  = pushValid && (!isFull || strobe.pop) && !strobe.flush;
  end

  assign ovrEvent = pushValid && isFull && !strobe.pop && !strobe.flush;
  assign udrEvent = holdRead && isEmpty && !strobe.flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
      udrFlag <= 1'b0;
    end else if (strobe.flush) begin
      ovrFlag <= 1'b0;
      udrFlag <= 1'b0;
    end else begin
      ovrFlag <= (ovrFlag && !statRead) || ovrEvent;
      udrFlag <= (udrFlag && !statRead) || udrEvent;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '0;
      burstSize <= 4'd1;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_ENSET: maskReg <= maskReg | regWrData[EVT_W-1:0];
        ADDR_ENCLR: maskReg <= maskReg & ~regWrData[EVT_W-1:0];
        ADDR_MODE: begin
          case (regWrData[31:28])
            4'd1, 4'd2, 4'd4, 4'd8: burstSize <= regWrData[31:28];
            default:                burstSize <= 4'd1;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign statusWord = {ovrFlag, udrFlag, burstHit, isFull, isEmpty, !isEmpty};

  always_comb begin
    case (regAddr)
      ADDR_HOLD:   regRdData = isEmpty ? 32'h0 : headWord;
      ADDR_MODE:   regRdData = {burstSize, 28'h0};
      ADDR_MASK:   regRdData = 32'(maskReg);
      ADDR_STATUS: regRdData = 32'(statusWord);
      ADDR_VER:    regRdData = 32'(VERSION & 12'hFFF);
      default:     regRdData = 32'h0;
    endcase
  end

  assign irq    = |(statusWord & maskReg);
  assign dmaReq = burstHit;
endmodule

// File: rtl/capture_queue_top.sv
module capture_queue_top
  import capture_queue_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CHAN_W   = 2,
  parameter int SAMPLE_W = 24,
  parameter int VERSION  = 12'h2B1,
  localparam int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [CHAN_W-1:0]   pushChan,
  input  logic [SAMPLE_W-1:0] pushSample,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [7:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic                irq,
  output logic                dmaReq
);
  queueStrobe_t     strobe;
  logic [31:0]      inWord, headWord;
  logic [CNT_W-1:0] fifoCount;
  logic [EVT_W-1:0] maskReg;
  logic             ovrFlag, udrFlag;

  assign inWord = {{(8 - CHAN_W){1'b0}}, pushChan, pushSample};

  capture_queue_store #(.DEPTH(DEPTH), .WORD_W(32)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWord(inWord),
    .headWord(headWord), .count(fifoCount)
  );

  capture_queue_ctrl #(.DEPTH(DEPTH), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .count(fifoCount), .headWord(headWord), .strobe(strobe),
    .regRdData(regRdData), .maskReg(maskReg), .ovrFlag(ovrFlag),
    .udrFlag(udrFlag), .irq(irq), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/capture_queue_checker.sv
module capture_queue_checker
  import capture_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushValid,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [7:0]       regAddr,
  input logic             flushNow,
  input logic [CNT_W-1:0] count,
  input logic [EVT_W-1:0] maskReg,
  input logic             ovrFlag,
  input logic             udrFlag,
  input logic             irq,
  input logic             dmaReq
);
  logic holdRd, maskWr;
  assign holdRd = regRdEn && (regAddr == ADDR_HOLD);
  assign maskWr = regWrEn && ((regAddr == ADDR_ENSET) || (regAddr == ADDR_ENCLR));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R1
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    holdRd && count == '0 && !flushNow |=> udrFlag); // R2
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && count == CNT_W'(DEPTH) && !holdRd && !flushNow |=> ovrFlag); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(maskReg)); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    maskReg == '0 |-> !irq); // R7
  AST_DMA_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    count == '0 |-> !dmaReq); // R8
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> count == '0 && !ovrFlag && !udrFlag); // R9
endmodule

bind capture_queue_top capture_queue_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .flushNow(strobe.flush),
  .count(fifoCount), .maskReg(maskReg), .ovrFlag(ovrFlag),
  .udrFlag(udrFlag), .irq(irq), .dmaReq(dmaReq)
);

// File: tb/tb_capture_queue_top.sv
`timescale 1ns/1ps
module tb_capture_queue_top;
  localparam int VER = 12'h2B1;
  localparam logic [31:0] VEC [8] = '{
    32'h00_123456, 32'h01_ABCDEF, 32'h02_000001, 32'h03_FFFFFF,
    32'h00_800000, 32'h03_7FFFFF, 32'h01_0F0F0F, 32'h02_A5A5A5};

  logic clk = 0, rstN = 0, pushValid = 0, regWrEn = 0, regRdEn = 0;
  logic [1:0] pushChan = 0;
  logic [23:0] pushSample = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData, rd;
  logic irq, dmaReq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  capture_queue_top #(.VERSION(VER)) dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushChan(pushChan),
    .pushSample(pushSample), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .dmaReq(dmaReq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); #1 regRdEn = 0;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1 regWrEn = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); pushValid = 1; pushChan = w[25:24]; pushSample = w[23:0];
    @(posedge clk); #1 pushValid = 0;
  endtask

  function automatic logic [31:0] fillWord(input int i);
    return {6'b0, 2'(i % 4), 24'(i * 24'h111 + 5)};
  endfunction

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R11 / R4 reset state
    rdReg(8'h20, rd); check("R11 status", rd, 32'h02);
    rdReg(8'h1C, rd); check("R11 mask", rd, 0);
    rdReg(8'h04, rd); check("R11 burst", rd, 32'h1000_0000);
    check("R11 irq", irq, 0); check("R11 dmaReq", dmaReq, 0);
    // R10
    rdReg(8'h50, rd); check("R10 version", rd, 32'(VER));
    rdReg(8'h44, rd); check("R10 unmapped", rd, 0);
    // R8 burst 4
    wrReg(8'h04, 32'h4000_0000);
    rdReg(8'h04, rd); check("R8 burst readback", rd, 32'h4000_0000);
    for (int i = 0; i < 3; i++) push(VEC[i]);
    check("R8 dma below burst", dmaReq, 0);
    push(VEC[3]);
    check("R8 dma at burst", dmaReq, 1);
    rdReg(8'h20, rd); check("R4 ready+burst", rd, 32'h09);
    for (int i = 4; i < 8; i++) push(VEC[i]);
    // R1 order and format
    for (int i = 0; i < 8; i++) begin
      rdReg(8'h0C, rd); check("R1 holding word", rd, VEC[i]);
    end
    rdReg(8'h20, rd); check("R4 empty again", rd, 32'h02);
    // R2 underrun
    rdReg(8'h0C, rd); check("R2 empty read", rd, 0);
    rdReg(8'h20, rd); check("R2 underrun flag", rd, 32'h12);
    rdReg(8'h20, rd); check("R5 cleared", rd, 32'h02);
    // R6 mask
    wrReg(8'h14, 32'h30);
    rdReg(8'h1C, rd); check("R6 enable", rd, 32'h30);
    wrReg(8'h18, 32'h10);
    rdReg(8'h1C, rd); check("R6 disable", rd, 32'h20);
    wrReg(8'h1C, 32'h3F);
    rdReg(8'h1C, rd); check("R6 mask write ignored", rd, 32'h20);
    // R3 overrun
    for (int i = 0; i < 16; i++) push(fillWord(i));
    rdReg(8'h20, rd); check("R4 full", rd, 32'h0D);
    check("R7 irq masked off", irq, 0);
    push(32'h01_DEAD00);
    check("R7 irq on overrun", irq, 1);
    rdReg(8'h20, rd); check("R3 overrun flag", rd, 32'h2D);
    check("R5 irq after clear", irq, 0);
    // R3 push and pop same cycle on full queue
    @(negedge clk);
    pushValid = 1; pushChan = 2'd3; pushSample = 24'h5A5A5A;
    regRdEn = 1; regAddr = 8'h0C;
    #1 check("R3 simultaneous pop word", regRdData, fillWord(0));
    @(posedge clk); #1 pushValid = 0; regRdEn = 0;
    rdReg(8'h20, rd); check("R3 no overrun on push+pop", rd, 32'h0D);
    for (int i = 1; i < 16; i++) begin
      rdReg(8'h0C, rd); check("R3 drain order", rd, fillWord(i));
    end
    rdReg(8'h0C, rd); check("R3 tail word", rd, 32'h03_5A5A5A);
    // R5 event during clearing read
    for (int i = 0; i < 16; i++) push(fillWord(i));
    @(negedge clk);
    pushValid = 1; regRdEn = 1; regAddr = 8'h20;
    #1 check("R5 old status", regRdData, 32'h0D);
    @(posedge clk); #1 pushValid = 0; regRdEn = 0;
    rdReg(8'h20, rd); check("R5 event kept", rd, 32'h2D);
    // R9 software reset with simultaneous push
    push(32'h0);
    @(negedge clk);
    regWrEn = 1; regAddr = 8'h00; regWrData = 32'h1;
    pushValid = 1; pushSample = 24'h111111;
    @(posedge clk); #1 regWrEn = 0; pushValid = 0;
    check("R9 irq low", irq, 0);
    rdReg(8'h20, rd); check("R9 status", rd, 32'h02);
    rdReg(8'h1C, rd); check("R9 mask kept", rd, 32'h20);
    rdReg(8'h04, rd); check("R9 burst kept", rd, 32'h4000_0000);
    // R8 illegal burst and burst 8 boundary
    wrReg(8'h04, 32'h3000_0000);
    rdReg(8'h04, rd); check("R8 illegal burst", rd, 32'h1000_0000);
    push(VEC[0]);
    check("R8 dma burst 1", dmaReq, 1);
    rdReg(8'h0C, rd);
    wrReg(8'h04, 32'h8000_0000);
    for (int i = 0; i < 7; i++) push(VEC[i]);
    check("R8 dma 7 of 8", dmaReq, 0);
    push(VEC[7]);
    check("R8 dma 8 of 8", dmaReq, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule